// File: doc/BRIEF.md
# Converter Configuration Bank with Clock-Domain Transfer

This block is the processor-facing configuration bank of a slow measurement converter. It holds one control/status register and two 8-bit threshold registers. The processor writes them in its own clock. Each accepted write is carried into the slower converter clock with a toggle request and acknowledge handshake. The converter side mirrors the register contents and uses them.

A single busy flag covers all three registers. While one transfer is in flight, the bank ignores every write, to any of the three registers. Software polls the flag before it writes again.

On the converter side, a small sequencer issues a one-cycle accumulate strobe. The strobe repeats every 1, 2, 4 or 8 base periods while the converter is enabled. The base period is set in converter clock ticks. A power-off input overrides the enable bit.

Top module: `meter_cfg_cdc`

## Requirements
- R1: After reset, all readable registers return zero, the busy flag is clear, the mirrored outputs are zero, the converter is disabled and no strobe is issued.
- R2: Address 0 is the control register. Bit 7 is the enable and bits 4:3 are the period code. Bit 6 and bits 2:0 always read zero, and writes to them have no effect. Address 1 is threshold A and address 2 is threshold B. Address 3 reads zero, ignores writes and starts no transfer.
- R3: Bit 5 of the control register is the busy flag. It reads one from the cycle after an accepted write until that write's acknowledge has returned to the processor clock. The staged write data stays unchanged during that time.
- R4: Any write made while busy is set is dropped, whichever of the three registers it targets. A write presented in the first cycle that busy reads zero is accepted.
- R5: Busy clears within 16 processor cycles of an accepted write when the converter clock is no slower than one third of the processor clock.
- R6: Once busy clears, the converter-domain outputs carry the written enable, period code and threshold values.
- R7: While power-off is high, the converter is disabled and no strobe is issued, whatever the enable bit holds. The strobe resumes after power-off is released.
- R8: While the converter is enabled, the strobe is a single-cycle pulse. Consecutive strobes are TICKS_BASE times 1, 2, 4 or 8 converter cycles apart, for period codes 00, 01, 10 and 11 respectively.
- R9: A new period code takes effect at the next strobe boundary. The period running when the code arrives completes at its old length.
- R10: Clearing the enable, or raising power-off, stops strobes at once and resets the sequencer. After the converter is enabled again, the first strobe comes TICKS_BASE converter cycles later with code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | Processor-side clock |
| clk_cnv_i | input | 1 | Converter-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 8 | Read data for addr_i |
| pwr_off_i | input | 1 | Power-off, converter domain; forces the converter off |
| cnv_en_o | output | 1 | Effective converter enable |
| cnv_per_o | output | 2 | Mirrored period code |
| cnv_thr_a_o | output | 8 | Mirrored threshold A |
| cnv_thr_b_o | output | 8 | Mirrored threshold B |
| acc_stb_o | output | 1 | Accumulate strobe, one converter cycle |

## Verification
The hard coincidence is a processor write that lands in the same cycle the returning acknowledge clears the busy flag. The bench provokes it by presenting a new control word on every cycle and reading busy in that same cycle. The word presented at the first idle reading must be the one that lands, and every earlier word must be lost. A second coincidence is a period-code change that arrives mid-period. It is judged by the scoreboard's expected gap list, which requires the old period to finish before the new one starts.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned PER_W    = 2;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned RSV_BIT  = 6;
  localparam int unsigned BUSY_BIT = 5;
  localparam int unsigned SEL_HI   = 4;
  localparam int unsigned SEL_LO   = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_THR_A = 2'd1,
    REG_THR_B = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic [PER_W-1:0] per;
    logic [REG_W-1:0] thr_a;
    logic [REG_W-1:0] thr_b;
  } regs_t;
endpackage

// File: rtl/mcc_sync2.sv
`timescale 1ns/1ps
module mcc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mcc_cpu_port.sv
`timescale 1ns/1ps
module mcc_cpu_port
  import mcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              ack_tgl_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              req_tgl_o,
  output logic [ADDR_W-1:0] hold_sel_o,
  output logic [REG_W-1:0]  hold_data_o,
  output logic              busy_o,
  output regs_t             shadow_o
);
  logic              ack_s;
  logic              req_q;
  logic              accept;
  logic [ADDR_W-1:0] hold_sel_q;
  logic [REG_W-1:0]  hold_data_q;
  regs_t             sh_q;

  mcc_sync2 #(.W(1)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl_i),
    .q_o    (ack_s)
  );

  assign busy_o = req_q ^ ack_s;
  // one transfer in flight at a time; address 3 never starts one
  assign accept = we_i & ~busy_o & (addr_i != REG_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= 1'b0;
      hold_sel_q  <= REG_CTRL;
      hold_data_q <= '0;
      sh_q        <= '0;
    end else if (accept) begin
      req_q       <= ~req_q;
      hold_sel_q  <= addr_i;
      hold_data_q <= wdata_i;
      case (addr_i)
        REG_CTRL: begin
          sh_q.en  <= wdata_i[EN_BIT];
          sh_q.per <= wdata_i[SEL_HI:SEL_LO];
        end
        REG_THR_A: sh_q.thr_a <= wdata_i;
        REG_THR_B: sh_q.thr_b <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[EN_BIT]        = sh_q.en;
        rdata_o[BUSY_BIT]      = busy_o;
        rdata_o[SEL_HI:SEL_LO] = sh_q.per;
      end
      REG_THR_A: rdata_o = sh_q.thr_a;
      REG_THR_B: rdata_o = sh_q.thr_b;
      default:   rdata_o = '0;
    endcase
  end

  assign req_tgl_o   = req_q;
  assign hold_sel_o  = hold_sel_q;
  assign hold_data_o = hold_data_q;
  assign shadow_o    = sh_q;
endmodule

// File: rtl/mcc_cnv_port.sv
`timescale 1ns/1ps
module mcc_cnv_port
  import mcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] hold_sel_i,
  input  logic [REG_W-1:0]  hold_data_i,
  output logic              ack_tgl_o,
  output regs_t             mirror_o
);
  logic  req_s;
  logic  ack_q;
  regs_t mir_q;

  mcc_sync2 #(.W(1)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_tgl_i),
    .q_o    (req_s)
  );

  // hold_* are quasi-static: only sampled on a request edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      mir_q <= '0;
    end else if (req_s != ack_q) begin
      ack_q <= req_s;
      case (hold_sel_i)
        REG_CTRL: begin
          mir_q.en  <= hold_data_i[EN_BIT];
          mir_q.per <= hold_data_i[SEL_HI:SEL_LO];
        end
        REG_THR_A: mir_q.thr_a <= hold_data_i;
        REG_THR_B: mir_q.thr_b <= hold_data_i;
        default: ;
      endcase
    end
  end

  assign ack_tgl_o = ack_q;
  assign mirror_o  = mir_q;
endmodule

// File: rtl/mcc_acc_seq.sv
`timescale 1ns/1ps
module mcc_acc_seq
  import mcc_pkg::*;
#(
  parameter int unsigned TICKS_BASE = 125000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] per_i,
  output logic             stb_o
);
  localparam int unsigned TW = (TICKS_BASE > 2) ? $clog2(TICKS_BASE) : 1;
  localparam int unsigned BW = (1 << PER_W) - 1;

  logic [TW-1:0]    tick_q;
  logic [BW-1:0]    base_q;
  logic [PER_W-1:0] per_act_q;
  logic [BW-1:0]    base_lim;
  logic             stb_q;
  logic             tick_last;

  always_comb begin
    base_lim = '0;
    for (int i = 0; i < BW; i++) begin
      base_lim[i] = (int'(per_act_q) > i);
    end
  end

  assign tick_last = (tick_q == TW'(TICKS_BASE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= '0;
      base_q    <= '0;
      per_act_q <= '0;
      stb_q     <= 1'b0;
    end else if (!run_i) begin
      // abort: restart from zero on next enable
      tick_q    <= '0;
      base_q    <= '0;
      per_act_q <= per_i;
      stb_q     <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (tick_last) begin
        tick_q <= '0;
        if (base_q == base_lim) begin
          base_q    <= '0;
          stb_q     <= 1'b1;
          per_act_q <= per_i;
        end else begin
          base_q <= base_q + 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/meter_cfg_cdc.sv
`timescale 1ns/1ps
module meter_cfg_cdc
  import mcc_pkg::*;
#(
  parameter int unsigned TICKS_BASE = 125000
) (
  input  logic              clk_cpu_i,
  input  logic              clk_cnv_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              pwr_off_i,
  output logic              cnv_en_o,
  output logic [PER_W-1:0]  cnv_per_o,
  output logic [REG_W-1:0]  cnv_thr_a_o,
  output logic [REG_W-1:0]  cnv_thr_b_o,
  output logic              acc_stb_o
);
  logic              req_tgl;
  logic              ack_tgl;
  logic              busy;
  logic [ADDR_W-1:0] hold_sel;
  logic [REG_W-1:0]  hold_data;
  regs_t             shadow;
  regs_t             mirror;
  logic              run;

  mcc_cpu_port u_cpu (
    .clk_i       (clk_cpu_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .we_i        (we_i),
    .ack_tgl_i   (ack_tgl),
    .rdata_o     (rdata_o),
    .req_tgl_o   (req_tgl),
    .hold_sel_o  (hold_sel),
    .hold_data_o (hold_data),
    .busy_o      (busy),
    .shadow_o    (shadow)
  );

  mcc_cnv_port u_cnv (
    .clk_i       (clk_cnv_i),
    .rst_ni      (rst_ni),
    .req_tgl_i   (req_tgl),
    .hold_sel_i  (hold_sel),
    .hold_data_i (hold_data),
    .ack_tgl_o   (ack_tgl),
    .mirror_o    (mirror)
  );

  assign run = mirror.en & ~pwr_off_i;

  mcc_acc_seq #(.TICKS_BASE(TICKS_BASE)) u_seq (
    .clk_i  (clk_cnv_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .per_i  (mirror.per),
    .stb_o  (acc_stb_o)
  );

  assign cnv_en_o    = run;
  assign cnv_per_o   = mirror.per;
  assign cnv_thr_a_o = mirror.thr_a;
  assign cnv_thr_b_o = mirror.thr_b;
endmodule

// File: rtl/mcc_chk.sv
`timescale 1ns/1ps
module mcc_chk
  import mcc_pkg::*;
(
  input logic              clk_cpu_i,
  input logic              clk_cnv_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              busy_i,
  input regs_t             sh_i,
  input logic [ADDR_W+REG_W-1:0] hold_i,
  input logic              pwr_off_i,
  input logic              cnv_en_o,
  input logic              acc_stb_o
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> (rdata_o[RSV_BIT] == 1'b0 && rdata_o[2:0] == 3'b000));

  // R3
  busy_set_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    (we_i && !busy_i && addr_i != REG_NONE) |=> busy_i);

  // R3
  hold_stable_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    busy_i |=> $stable(hold_i));

  // R4
  blocked_write_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    busy_i |=> $stable(sh_i));

  // R7
  pwr_off_chk: assert property (@(posedge clk_cnv_i) disable iff (!rst_ni)
    pwr_off_i |=> !acc_stb_o);

  // R8
  stb_gate_chk: assert property (@(posedge clk_cnv_i) disable iff (!rst_ni)
    acc_stb_o |-> $past(cnv_en_o));

  // R8
  stb_pulse_chk: assert property (@(posedge clk_cnv_i) disable iff (!rst_ni)
    acc_stb_o |=> !acc_stb_o);
endmodule

bind meter_cfg_cdc mcc_chk u_chk (
  .clk_cpu_i (clk_cpu_i),
  .clk_cnv_i (clk_cnv_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .busy_i    (busy),
  .sh_i      (shadow),
  .hold_i    ({hold_sel, hold_data}),
  .pwr_off_i (pwr_off_i),
  .cnv_en_o  (cnv_en_o),
  .acc_stb_o (acc_stb_o)
);

// File: tb/meter_cfg_cdc_bench.sv
`timescale 1ns/1ps
module meter_cfg_cdc_bench;
  localparam int TB = 6;

  logic       clk_cpu = 1'b0;
  logic       clk_cnv = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] addr    = 2'd0;
  logic [7:0] wdata   = 8'h00;
  logic       we      = 1'b0;
  logic [7:0] rdata;
  logic       pwr_off = 1'b0;
  logic       cnv_en;
  logic [1:0] cnv_per;
  logic [7:0] thr_a, thr_b;
  logic       stb;

  int errors = 0;
  int checks = 0;
  int stb_cnt = 0;
  int since = 0;
  bit armed = 1'b0;
  int exp_q[$];

  always #2.5 clk_cpu = ~clk_cpu;
  always #7   clk_cnv = ~clk_cnv;

  meter_cfg_cdc #(.TICKS_BASE(TB)) u_meter_cfg_cdc (
    .clk_cpu_i   (clk_cpu),
    .clk_cnv_i   (clk_cnv),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .we_i        (we),
    .rdata_o     (rdata),
    .pwr_off_i   (pwr_off),
    .cnv_en_o    (cnv_en),
    .cnv_per_o   (cnv_per),
    .cnv_thr_a_o (thr_a),
    .cnv_thr_b_o (thr_b),
    .acc_stb_o   (stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: strobe gaps popped against the expected queue
  always @(negedge clk_cnv) begin
    if (stb) begin
      stb_cnt <= stb_cnt + 1;
      if (armed && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk((since + 1) == e, "R8/R9 strobe gap", since + 1, e);
      end
      since <= 0;
    end else begin
      since <= since + 1;
    end
  end

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_cpu);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk_cpu);
    we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_cpu);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0;
    do begin
      cpu_rd(2'd0, v);
      n++;
    end while (v[5] && n < 64);
  endtask

  task automatic wait_strobes(input int k);
    int c0;
    c0 = stb_cnt;
    while (stb_cnt < c0 + k) @(negedge clk_cnv);
  endtask

  // driver: push expected gaps, arm, drain
  task automatic expect_gaps(input int g, input int k);
    wait_strobes(1);
    for (int i = 0; i < k; i++) exp_q.push_back(g);
    armed = 1'b1;
    while (exp_q.size() != 0) @(negedge clk_cnv);
    armed = 1'b0;
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_ctrl;
    int n, c0, k;
    bit done;

    #20 rst_n = 1'b1;
    repeat (3) @(negedge clk_cpu);

    // R1 reset state
    cpu_rd(2'd0, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    cpu_rd(2'd1, v); chk(v == 8'h00, "R1 thr_a reset", v, 0);
    cpu_rd(2'd2, v); chk(v == 8'h00, "R1 thr_b reset", v, 0);
    chk(cnv_en == 1'b0 && cnv_per == 2'd0 && thr_a == 8'h00 && thr_b == 8'h00,
        "R1 mirror reset", {cnv_en, cnv_per, thr_a, thr_b}, 0);
    repeat (20) @(negedge clk_cnv);
    chk(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);

    // R3 busy, R4 drop, R5 bound, R6 mirror
    cpu_wr(2'd1, 8'h5A);
    cpu_rd(2'd0, v); chk(v[5] == 1'b1, "R3 busy after write", v[5], 1);
    cpu_wr(2'd2, 8'h33);
    wait_idle(n);
    chk(n <= 16, "R5 busy clear bound", n, 16);
    cpu_rd(2'd1, v); chk(v == 8'h5A, "R6 thr_a readback", v, 8'h5A);
    cpu_rd(2'd2, v); chk(v == 8'h00, "R4 thr_b write dropped", v, 0);
    chk(thr_a == 8'h5A, "R6 thr_a mirror", thr_a, 8'h5A);
    chk(thr_b == 8'h00, "R4 thr_b mirror untouched", thr_b, 0);

    cpu_wr(2'd2, 8'hC3);
    wait_idle(n);
    chk(thr_b == 8'hC3, "R6 thr_b mirror", thr_b, 8'hC3);

    // R2 address 3 ignored, no transfer
    cpu_wr(2'd3, 8'hFF);
    cpu_rd(2'd0, v); chk(v[5] == 1'b0, "R2 addr3 no busy", v[5], 0);
    cpu_rd(2'd3, v); chk(v == 8'h00, "R2 addr3 reads zero", v, 0);

    // R2 reserved bits, enable with code 00
    cpu_wr(2'd0, 8'hC7);
    wait_idle(n);
    cpu_rd(2'd0, v); chk(v == 8'h80, "R2 ctrl reserved bits", v, 8'h80);
    chk(cnv_en == 1'b1 && cnv_per == 2'd0, "R6 ctrl mirror", {cnv_en, cnv_per}, 4);

    // R8 each period code
    for (int s = 0; s < 4; s++) begin
      cpu_wr(2'd0, 8'h80 | 8'(s << 3));
      wait_idle(n);
      chk(cnv_per == 2'(s), "R6 period mirror", cnv_per, s);
      wait_strobes(1);
      expect_gaps(TB << s, 3);
    end

    // R9 change 11 -> 00 mid-period: old 8x period completes first
    wait_strobes(1);
    exp_q.push_back(TB * 8);
    exp_q.push_back(TB);
    exp_q.push_back(TB);
    armed = 1'b1;
    cpu_wr(2'd0, 8'h80);
    while (exp_q.size() != 0) @(negedge clk_cnv);
    armed = 1'b0;

    // R4 write in the cycle busy clears lands; earlier ones are lost
    @(negedge clk_cpu);
    addr = 2'd0; wdata = 8'h85; we = 1'b1;
    exp_ctrl = 8'h00;
    done = 1'b0;
    k = 1;
    while (!done && k < 40) begin
      @(negedge clk_cpu);
      wdata = ((k % 2) != 0 ? 8'h00 : 8'h80) | 8'(((k / 2) % 4) << 3) | 8'h05;
      #0.5;
      if (rdata[5] == 1'b0) begin
        exp_ctrl = wdata & 8'h98;
        done = 1'b1;
      end
      k++;
    end
    @(negedge clk_cpu);
    we = 1'b0;
    chk(done && k <= 17, "R5 busy clear under hammer", k, 17);
    wait_idle(n);
    cpu_rd(2'd0, v); chk(v == exp_ctrl, "R4 same-cycle write lands", v, exp_ctrl);
    chk({cnv_en, cnv_per} == {exp_ctrl[7], exp_ctrl[4:3]}, "R4 same-cycle mirror",
        {cnv_en, cnv_per}, {exp_ctrl[7], exp_ctrl[4:3]});

    // R10 clearing enable halts strobes
    cpu_wr(2'd0, 8'h80);
    wait_idle(n);
    cpu_wr(2'd0, 8'h00);
    wait_idle(n);
    @(negedge clk_cnv);
    c0 = stb_cnt;
    repeat (60) @(negedge clk_cnv);
    chk(stb_cnt == c0 && cnv_en == 1'b0, "R10 disable halts", stb_cnt - c0, 0);

    // R7 power-off overrides enable
    cpu_wr(2'd0, 8'h80);
    wait_idle(n);
    wait_strobes(1);
    @(negedge clk_cnv);
    pwr_off = 1'b1;
    #0.5;
    chk(cnv_en == 1'b0, "R7 power-off disables", cnv_en, 0);
    @(negedge clk_cnv);
    c0 = stb_cnt;
    repeat (40) @(negedge clk_cnv);
    chk(stb_cnt == c0, "R7 no strobe in power-off", stb_cnt - c0, 0);
    cpu_rd(2'd0, v); chk(v == 8'h80, "R7 register kept", v, 8'h80);

    // R10 restart from zero after release
    @(negedge clk_cnv);
    pwr_off = 1'b0;
    n = 0;
    c0 = stb_cnt;
    while (stb_cnt == c0 && n < 100) begin
      @(negedge clk_cnv);
      n++;
      #0.1;
    end
    chk(n == TB, "R10 first strobe after restart", n, TB);
    c0 = stb_cnt;
    repeat (20) @(negedge clk_cnv);
    chk(stb_cnt > c0, "R7 strobes resume", stb_cnt - c0, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule